// File: doc/BRIEF.md
# PCI Slot Hotplug Status Window

This block is the register window that firmware polls to track insertion and removal of PCI devices on a set of hotplug-capable buses. Each bus carries three 32-slot bitmaps: slots with an insertion waiting to be noticed, slots with a removal request waiting to be serviced, and a mask of slots that may be removed. A platform model reports insertions and removal requests through side-band strobes. Each strobe raises a one-cycle event pulse toward the interrupt logic.

Firmware uses aligned 32-bit accesses. It first writes a bus index into a select register. It then reads the bitmaps of that bus and writes an eject bitmap. An eject services one slot, the lowest set bit, and emits an unplug command carrying the bus and slot index. A legacy mode keeps the insert bitmap from clearing on read and pins the select register to bus 0.

A platform reset request starts a walk over all buses. The walk ejects every slot still pending removal, and then it rebuilds each removable mask from the per-bus non-hotpluggable and occupied inputs.

Top module: `pcihp_regblk`

## Requirements
- R1: After rst_n is released, every insert and remove bitmap reads zero, every removable mask reads 32'hFFFF_FFFF, the select register reads 0, and neither event_pulse nor unplug_valid is high.
- R2: An access is accepted only when reg_be is 4'hF. Offsets decode as 0x00 insert, 0x04 remove, 0x08 eject, 0x0C removable and 0x10 select. An access with any other byte-enable has no effect.
- R3: A read of offset 0x00 returns the selected bus's insert bitmap. Outside legacy mode it also clears that bitmap. With legacy_mode high the bitmap is kept.
- R4: Offset 0x04 returns the selected bus's remove bitmap, offset 0x0C returns its removable mask, and offset 0x08 always reads zero.
- R5: A write to offset 0x08 takes the lowest set bit of the data as the slot. It clears that slot in both bitmaps of the selected bus. One cycle later it pulses unplug_valid for one cycle with that bus and slot, unless nohp_mask marks the slot. A zero write does nothing.
- R6: With legacy_mode high, a write to offset 0x10 stores 0 whatever the data. Otherwise the full 32-bit value is stored.
- R7: When the select value is NUM_BUS or more, every read returns zero and eject writes have no effect.
- R8: A plug strobe sets the slot's bit in the bus's insert bitmap. A removal-request strobe sets the bit in the remove bitmap. Either strobe raises event_pulse for one cycle on the next cycle. A strobe naming a bus at or above NUM_BUS is ignored.
- R9: When a strobe sets a bit in the same cycle as a read-clear or eject of the same bitmap, the bit ends up set.
- R10: A plat_reset_req pulse ejects every pending remove slot, bus by bus, lowest slot first, with an unplug command for each hotpluggable slot. It then sets each bus's removable mask to all ones minus the slots that are both occupied and marked non-hotpluggable. Register ejects are ignored while this walk runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_mode | input | 1 | Selects legacy register behaviour |
| plat_reset_req | input | 1 | One-cycle platform reset request that starts the eject walk |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset in the window |
| reg_be | input | 4 | Byte enables; only 4'hF is accepted |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the access cycle |
| plug_valid | input | 1 | Insertion strobe |
| plug_bus | input | EV_BUS_W | Bus of the insertion |
| plug_slot | input | 5 | Slot of the insertion |
| unreq_valid | input | 1 | Removal-request strobe |
| unreq_bus | input | EV_BUS_W | Bus of the removal request |
| unreq_slot | input | 5 | Slot of the removal request |
| nohp_mask | input | NUM_BUS x 32 | Per-bus mask of slots that may not be hot-removed |
| occupied | input | NUM_BUS x 32 | Per-bus mask of populated slots |
| event_pulse | output | 1 | One-cycle pulse after any accepted strobe |
| unplug_valid | output | 1 | One-cycle unplug command strobe |
| unplug_bus | output | BUS_W | Bus of the unplug command |
| unplug_slot | output | 5 | Slot of the unplug command |

## Verification
The assertions assume that nohp_mask and occupied stay steady from an eject until the resulting unplug command appears, and that strobes and register accesses are single-cycle pulses. The bench changes those masks only while no eject or reset walk is in flight. It holds each access or strobe for exactly one clock, and it runs the simultaneous read-clear and plug case as a deliberate single overlap. Expected unplug commands are queued before the write or reset request that causes them, so ordering across the reset walk is checked.

// File: rtl/pcihp_pkg.sv
package pcihp_pkg;
    localparam int SLOT_N = 32;
    localparam int SLOT_W = 5;

    localparam logic [4:0] OFS_INS = 5'h00;
    localparam logic [4:0] OFS_REM = 5'h04;
    localparam logic [4:0] OFS_EJ  = 5'h08;
    localparam logic [4:0] OFS_RMV = 5'h0C;
    localparam logic [4:0] OFS_SEL = 5'h10;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_RD_INS,
        OP_RD_REM,
        OP_RD_EJ,
        OP_RD_RMV,
        OP_RD_SEL,
        OP_WR_EJ,
        OP_WR_SEL
    } acc_op_e;
endpackage

// File: rtl/pcihp_acc_dec.sv
module pcihp_acc_dec
    import pcihp_pkg::*;
(
    input  logic       acc_valid,
    input  logic       acc_write,
    input  logic [4:0] acc_addr,
    input  logic [3:0] acc_be,
    output acc_op_e    acc_op
);
    always_comb begin
        acc_op = OP_NONE;
        if (acc_valid && acc_be == 4'hF) begin
            if (acc_write) begin
                case (acc_addr)
                    OFS_EJ:  acc_op = OP_WR_EJ;
                    OFS_SEL: acc_op = OP_WR_SEL;
                    default: acc_op = OP_NONE;
                endcase
            end else begin
                case (acc_addr)
                    OFS_INS: acc_op = OP_RD_INS;
                    OFS_REM: acc_op = OP_RD_REM;
                    OFS_EJ:  acc_op = OP_RD_EJ;
                    OFS_RMV: acc_op = OP_RD_RMV;
                    OFS_SEL: acc_op = OP_RD_SEL;
                    default: acc_op = OP_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/pcihp_lowbit.sv
module pcihp_lowbit #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = i[IW-1:0];
        end
    end
endmodule

// File: rtl/pcihp_regblk.sv
module pcihp_regblk
    import pcihp_pkg::*;
#(
    parameter int NUM_BUS  = 4,
    parameter int EV_BUS_W = 8,
    parameter int BUS_W    = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          legacy_mode,
    input  logic                          plat_reset_req,
    input  logic                          reg_valid,
    input  logic                          reg_write,
    input  logic [4:0]                    reg_addr,
    input  logic [3:0]                    reg_be,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    input  logic                          plug_valid,
    input  logic [EV_BUS_W-1:0]           plug_bus,
    input  logic [SLOT_W-1:0]             plug_slot,
    input  logic                          unreq_valid,
    input  logic [EV_BUS_W-1:0]           unreq_bus,
    input  logic [SLOT_W-1:0]             unreq_slot,
    input  logic [NUM_BUS-1:0][SLOT_N-1:0] nohp_mask,
    input  logic [NUM_BUS-1:0][SLOT_N-1:0] occupied,
    output logic                          event_pulse,
    output logic                          unplug_valid,
    output logic [BUS_W-1:0]              unplug_bus,
    output logic [SLOT_W-1:0]             unplug_slot
);
    localparam logic [BUS_W-1:0] LAST_BUS = BUS_W'(NUM_BUS - 1);

    typedef struct packed {
        logic [NUM_BUS-1:0][SLOT_N-1:0] ins;
        logic [NUM_BUS-1:0][SLOT_N-1:0] rem;
        logic [NUM_BUS-1:0][SLOT_N-1:0] rmv;
        logic [31:0]                    sel;
        logic                           walk_on;
        logic [BUS_W-1:0]               walk_bus;
        logic                           evt;
        logic                           unp_v;
        logic [BUS_W-1:0]               unp_bus;
        logic [SLOT_W-1:0]              unp_slot;
    } state_t;

    state_t st_d, st_q;
    acc_op_e op;

    logic              sel_ok;
    logic [BUS_W-1:0]  sel_bus;
    logic              wj_found, wk_found;
    logic [SLOT_W-1:0] wj_idx, wk_idx;
    logic              plug_ok, unreq_ok;

    pcihp_acc_dec dec_i (
        .acc_valid (reg_valid),
        .acc_write (reg_write),
        .acc_addr  (reg_addr),
        .acc_be    (reg_be),
        .acc_op    (op)
    );

    pcihp_lowbit #(.W(SLOT_N), .IW(SLOT_W)) ej_low_i (
        .vec   (reg_wdata),
        .found (wj_found),
        .idx   (wj_idx)
    );

    pcihp_lowbit #(.W(SLOT_N), .IW(SLOT_W)) walk_low_i (
        .vec   (st_q.rem[st_q.walk_bus]),
        .found (wk_found),
        .idx   (wk_idx)
    );

    assign sel_ok   = st_q.sel < 32'(NUM_BUS);
    assign sel_bus  = st_q.sel[BUS_W-1:0];
    assign plug_ok  = plug_valid && (plug_bus < EV_BUS_W'(NUM_BUS));
    assign unreq_ok = unreq_valid && (unreq_bus < EV_BUS_W'(NUM_BUS));

    always_comb begin
        st_d       = st_q;
        st_d.evt   = 1'b0;
        st_d.unp_v = 1'b0;
        reg_rdata  = '0;

        if (sel_ok) begin
            case (op)
                OP_RD_INS: reg_rdata = st_q.ins[sel_bus];
                OP_RD_REM: reg_rdata = st_q.rem[sel_bus];
                OP_RD_RMV: reg_rdata = st_q.rmv[sel_bus];
                OP_RD_SEL: reg_rdata = st_q.sel;
                default:   reg_rdata = '0;
            endcase
        end

        if (op == OP_RD_INS && sel_ok && !legacy_mode)
            st_d.ins[sel_bus] = '0;

        if (op == OP_WR_SEL)
            st_d.sel = legacy_mode ? 32'd0 : reg_wdata;

        if (op == OP_WR_EJ && sel_ok && !st_q.walk_on && wj_found) begin
            st_d.ins[sel_bus][wj_idx] = 1'b0;
            st_d.rem[sel_bus][wj_idx] = 1'b0;
            if (!nohp_mask[sel_bus][wj_idx]) begin
                st_d.unp_v    = 1'b1;
                st_d.unp_bus  = sel_bus;
                st_d.unp_slot = wj_idx;
            end
        end

        if (st_q.walk_on) begin
            if (wk_found) begin
                st_d.ins[st_q.walk_bus][wk_idx] = 1'b0;
                st_d.rem[st_q.walk_bus][wk_idx] = 1'b0;
                if (!nohp_mask[st_q.walk_bus][wk_idx]) begin
                    st_d.unp_v    = 1'b1;
                    st_d.unp_bus  = st_q.walk_bus;
                    st_d.unp_slot = wk_idx;
                end
            end else if (st_q.walk_bus == LAST_BUS) begin
                st_d.walk_on = 1'b0;
                for (int b = 0; b < NUM_BUS; b++)
                    st_d.rmv[b] = ~(nohp_mask[b] & occupied[b]);
            end else begin
                st_d.walk_bus = st_q.walk_bus + 1'b1;
            end
        end

        if (plat_reset_req) begin
            st_d.walk_on  = 1'b1;
            st_d.walk_bus = '0;
        end

        if (plug_ok) begin
            st_d.ins[plug_bus[BUS_W-1:0]][plug_slot] = 1'b1;
            st_d.evt = 1'b1;
        end
        if (unreq_ok) begin
            st_d.rem[unreq_bus[BUS_W-1:0]][unreq_slot] = 1'b1;
            st_d.evt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.rmv <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign event_pulse  = st_q.evt;
    assign unplug_valid = st_q.unp_v;
    assign unplug_bus   = st_q.unp_bus;
    assign unplug_slot  = st_q.unp_slot;

    // R8
    evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plug_ok || unreq_ok) |=> event_pulse);

    // R9
    ins_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        plug_ok |=> st_q.ins[$past(plug_bus[BUS_W-1:0])][$past(plug_slot)]);

    // R9
    rem_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unreq_ok |=> st_q.rem[$past(unreq_bus[BUS_W-1:0])][$past(unreq_slot)]);

    // R6
    legacy_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WR_SEL && legacy_mode) |=> (st_q.sel == 32'd0));

    // R7
    oob_eject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WR_EJ && !sel_ok && !st_q.walk_on) |=> !unplug_valid);

    // R5
    unplug_hp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unplug_valid |-> !nohp_mask[unplug_bus][unplug_slot]);

    // R4
    ej_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RD_EJ) |-> (reg_rdata == 32'd0));
endmodule

// File: tb/pcihp_regblk_tb.sv
module pcihp_regblk_tb_top;
    localparam int NB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic legacy_mode = 1'b0;
    logic plat_reset_req = 1'b0;
    logic reg_valid = 1'b0, reg_write = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [3:0] reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic plug_valid = 1'b0, unreq_valid = 1'b0;
    logic [7:0] plug_bus = '0, unreq_bus = '0;
    logic [4:0] plug_slot = '0, unreq_slot = '0;
    logic [NB-1:0][31:0] nohp_mask = '0;
    logic [NB-1:0][31:0] occupied = '0;
    logic event_pulse, unplug_valid;
    logic [1:0] unplug_bus;
    logic [4:0] unplug_slot;

    int checks = 0;
    int failures = 0;
    int exp_q[$];

    always #4 clk = ~clk;

    pcihp_regblk #(.NUM_BUS(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
        .plat_reset_req(plat_reset_req),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .plug_valid(plug_valid), .plug_bus(plug_bus), .plug_slot(plug_slot),
        .unreq_valid(unreq_valid), .unreq_bus(unreq_bus), .unreq_slot(unreq_slot),
        .nohp_mask(nohp_mask), .occupied(occupied),
        .event_pulse(event_pulse), .unplug_valid(unplug_valid),
        .unplug_bus(unplug_bus), .unplug_slot(unplug_slot)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a; reg_be = 4'hF;
        #1 chk(reg_rdata === exp, req, reg_rdata, exp);
        @(posedge clk); #1 reg_valid = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        @(posedge clk); #1 reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic strobe(input bit rem, input logic [7:0] b, input logic [4:0] s,
                          input bit exp_pulse, input string req);
        @(negedge clk);
        if (rem) begin unreq_valid = 1'b1; unreq_bus = b; unreq_slot = s; end
        else begin plug_valid = 1'b1; plug_bus = b; plug_slot = s; end
        @(posedge clk); #1 plug_valid = 1'b0; unreq_valid = 1'b0;
        chk(event_pulse === exp_pulse, req, {31'd0, event_pulse}, {31'd0, exp_pulse});
        @(posedge clk); #1
        chk(event_pulse === 1'b0, req, {31'd0, event_pulse}, 32'd0);
    endtask

    // Scoreboard monitor for unplug commands (R5, R10)
    always @(negedge clk) begin
        if (rst_n && unplug_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5/R10 unexpected unplug", {25'd0, unplug_bus, unplug_slot}, 32'd0);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk({25'd0, unplug_bus, unplug_slot} == 32'(e), "R5/R10 unplug cmd",
                    {25'd0, unplug_bus, unplug_slot}, 32'(e));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk(event_pulse === 1'b0 && unplug_valid === 1'b0, "R1 outputs idle",
            {30'd0, event_pulse, unplug_valid}, 32'd0);
        rd(5'h10, 32'd0, "R1 select");
        rd(5'h0C, 32'hFFFF_FFFF, "R1 removable");
        rd(5'h00, 32'd0, "R1 insert");
        rd(5'h04, 32'd0, "R1 remove");

        // R8 plug and R3 clear on read
        strobe(1'b0, 8'd1, 5'd5, 1'b1, "R8 plug pulse");
        wr(5'h10, 32'd1, 4'hF);
        rd(5'h00, 32'h20, "R3 insert read");
        rd(5'h00, 32'h0, "R3 insert cleared");
        strobe(1'b0, 8'd5, 5'd2, 1'b0, "R8 out-of-range bus ignored");

        // R3/R6 legacy
        legacy_mode = 1'b1;
        strobe(1'b0, 8'd1, 5'd7, 1'b1, "R8 plug pulse legacy");
        rd(5'h00, 32'h80, "R3 legacy read");
        rd(5'h00, 32'h80, "R3 legacy kept");
        wr(5'h10, 32'd3, 4'hF);
        rd(5'h10, 32'd0, "R6 legacy select forced");
        legacy_mode = 1'b0;

        // R4/R5 remove bitmap and lowest-bit eject
        strobe(1'b1, 8'd2, 5'd3, 1'b1, "R8 unreq pulse");
        strobe(1'b1, 8'd2, 5'd9, 1'b1, "R8 unreq pulse");
        wr(5'h10, 32'd2, 4'hF);
        rd(5'h10, 32'd2, "R6 select stored");
        rd(5'h04, 32'h208, "R4 remove read");
        exp_q.push_back(2 * 32 + 3);
        wr(5'h08, 32'h208, 4'hF);
        rd(5'h04, 32'h200, "R5 only lowest slot ejected");
        rd(5'h08, 32'd0, "R4 eject reads zero");
        nohp_mask[2] = 32'h200;
        wr(5'h08, 32'h200, 4'hF);
        rd(5'h04, 32'h0, "R5 non-hotpluggable cleared without command");
        wr(5'h08, 32'h0, 4'hF);
        rd(5'h0C, 32'hFFFF_FFFF, "R4 removable read");

        // R2 partial byte enables ignored
        wr(5'h10, 32'd1, 4'h3);
        rd(5'h10, 32'd2, "R2 partial write ignored");

        // R7 out-of-range select
        wr(5'h10, 32'd7, 4'hF);
        rd(5'h10, 32'd0, "R7 select read zero");
        rd(5'h0C, 32'd0, "R7 removable read zero");
        wr(5'h08, 32'h1, 4'hF);
        chk(unplug_valid === 1'b0, "R7 eject ignored", {31'd0, unplug_valid}, 32'd0);

        // R9 plug wins over same-cycle read-clear
        wr(5'h10, 32'd1, 4'hF);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = 5'h00; reg_be = 4'hF;
        plug_valid = 1'b1; plug_bus = 8'd1; plug_slot = 5'd4;
        #1 chk(reg_rdata === 32'h80, "R9 read value", reg_rdata, 32'h80);
        @(posedge clk); #1 reg_valid = 1'b0; plug_valid = 1'b0;
        rd(5'h00, 32'h10, "R9 new plug kept");

        // R10 platform reset walk
        strobe(1'b1, 8'd0, 5'd6, 1'b1, "R8 unreq pulse");
        strobe(1'b1, 8'd0, 5'd2, 1'b1, "R8 unreq pulse");
        strobe(1'b1, 8'd3, 5'd1, 1'b1, "R8 unreq pulse");
        nohp_mask[3] = 32'h2;
        nohp_mask[0] = 32'h1;
        occupied[0]  = 32'h1;
        occupied[2]  = 32'h200;
        exp_q.push_back(0 * 32 + 2);
        exp_q.push_back(0 * 32 + 6);
        @(negedge clk); plat_reset_req = 1'b1;
        @(posedge clk); #1 plat_reset_req = 1'b0;
        repeat (20) @(posedge clk);
        wr(5'h10, 32'd0, 4'hF);
        rd(5'h04, 32'd0, "R10 bus0 remove drained");
        rd(5'h0C, 32'hFFFF_FFFE, "R10 bus0 removable");
        wr(5'h10, 32'd2, 4'hF);
        rd(5'h0C, 32'hFFFF_FDFF, "R10 bus2 removable");
        wr(5'h10, 32'd3, 4'hF);
        rd(5'h04, 32'd0, "R10 bus3 remove drained");
        wr(5'h10, 32'd1, 4'hF);
        rd(5'h0C, 32'hFFFF_FFFF, "R10 bus1 removable");

        repeat (3) @(posedge clk);
        chk(exp_q.size() == 0, "R5/R10 all commands seen", 32'(exp_q.size()), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule